// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog timer that sits behind a small register interface. Its control word holds an enable, a reset-on-expiry enable and an exponent that picks the timeout as a power of two of the input clock. Software changes the control word only by writing two unlock words first, with no other control write between them. The running count is restarted only by a separate pair of restart words written back to back. When the count rolls over while the timer is armed, the block either issues a one-cycle system reset request and latches a sticky reset-cause flag, or it latches only an interrupt flag. Software clears these flags by writing ones to them.

An echo-mode input, while high, blocks every write to the control address. Blocked writes do not advance a key sequence. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. A write strobe with address and data takes effect at the next rising clock edge. Read data is combinational from the address. The `SIM_SHIFT` parameter divides every timeout by 2^SIM_SHIFT, so that short simulations can test the exponents. At the default of 0, selection 30 is 2^30 clocks, about 32.5 s at roughly 33 MHz.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, a control read (address 0) returns 16'h001E: enable clear, reset-enable clear, exponent 30. A status read (address 1) returns 0, and `sys_rst_req` and `wdog_irq` are low.
- R2: A non-key control write changes the control word only when the two control writes just before it were 16'h3333 and then 16'hCCCC. Otherwise it is ignored.
- R3: Any control write between the two unlock words aborts the unlock, and so does any control write after 16'hCCCC that was not itself preceded by 16'h3333.
- R4: The four key words (16'h3333, 16'hCCCC, 16'hAAAA, 16'h5555) are never stored, even in the slot after an unlock. Control reads return bit 15 = enable, bit 14 = reset-enable and bits 4:0 = exponent, with the other bits zero.
- R5: The count restarts from zero only when 16'hAAAA and then 16'h5555 are the two most recent control writes. A broken pair leaves the count running.
- R6: With exponent s, an armed timer expires every 2^max(1, s − SIM_SHIFT) clocks. The first expiry comes that many clocks after the count was cleared. A committed exponent above 30 is stored as 30.
- R7: An expiry with both enable and reset-enable set raises `sys_rst_req` for exactly one cycle and sets status bit 0.
- R8: An expiry with reset-enable clear sets status bit 1, which drives `wdog_irq`, and raises no reset request.
- R9: While enable is clear, the count is held at zero and nothing expires. Every committed control word clears the count.
- R10: A write to the status address clears each status bit written as 1 and leaves the bits written as 0.
- R11: While `echo_mode` is high, control writes have no effect: no commit, no restart and no progress in a key sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Register address: 0 control, 1 status |
| bus_wdata | input | 16 | Write data |
| echo_mode | input | 1 | High blocks all control-address writes |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| sys_rst_req | output | 1 | One-cycle system reset request |
| wdog_irq | output | 1 | Expiry-without-reset flag (status bit 1) |

## Verification
The assertions assume that `bus_wr`, `bus_addr`, `bus_wdata` and `echo_mode` are known and steady around each rising edge, and that each write is a single-cycle strobe. The control-word checks also assume that a write in one cycle is seen only at the following edge. To stay inside these assumptions, the stimulus changes every input on the falling edge and holds a strobe for exactly one clock. Key words, restart pairs and echo changes are placed so that expiry intervals can be measured from a known clear of the count.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int DATA_W = 16;
  localparam int SEL_W  = 5;
  localparam int ENA_BIT = 15;
  localparam int REN_BIT = 14;

  localparam logic [DATA_W-1:0] KEY_OPEN_A  = 16'h3333;
  localparam logic [DATA_W-1:0] KEY_OPEN_B  = 16'hCCCC;
  localparam logic [DATA_W-1:0] KEY_KICK_A  = 16'hAAAA;
  localparam logic [DATA_W-1:0] KEY_KICK_B  = 16'h5555;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_HALF  = 2'd1,
    SEQ_OPEN  = 2'd2,
    SEQ_KICK1 = 2'd3
  } seq_e;
endpackage

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
  import wdk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              commit_o,
  output logic              restart_o
);
  seq_e state_q, state_d;
  logic is_open_a, is_open_b, is_kick_a, is_kick_b, is_key;

  assign is_open_a = (data_i == KEY_OPEN_A);
  assign is_open_b = (data_i == KEY_OPEN_B);
  assign is_kick_a = (data_i == KEY_KICK_A);
  assign is_kick_b = (data_i == KEY_KICK_B);
  assign is_key    = is_open_a | is_open_b | is_kick_a | is_kick_b;

  always_comb begin
    state_d   = state_q;
    commit_o  = 1'b0;
    restart_o = 1'b0;
    if (wr_i) begin
      if (is_open_a)      state_d = SEQ_HALF;
      else if (is_open_b) state_d = (state_q == SEQ_HALF) ? SEQ_OPEN : SEQ_IDLE;
      else if (is_kick_a) state_d = SEQ_KICK1;
      else if (is_kick_b) begin
        restart_o = (state_q == SEQ_KICK1);
        state_d   = SEQ_IDLE;
      end else begin
        commit_o = (state_q == SEQ_OPEN) && !is_key;
        state_d  = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  // R2
  commit_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> (state_q == SEQ_IDLE));
  // R5
  restart_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> (state_q == SEQ_IDLE));
endmodule

// File: rtl/wdk_timer.sv
module wdk_timer
  import wdk_pkg::*;
#(
  parameter int MAX_SEL   = 30,
  parameter int SIM_SHIFT = 0
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ena_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             clear_i,
  output logic             expire_o
);
  localparam int CW = MAX_SEL - SIM_SHIFT;

  logic [CW-1:0] cnt_q, mask;
  int eff;

  always_comb begin
    eff = int'(sel_i) - SIM_SHIFT;
    if (eff < 1)  eff = 1;
    if (eff > CW) eff = CW;
  end

  for (genvar i = 0; i < CW; i++) begin : g_mask
    assign mask[i] = (i < eff);
  end

  assign expire_o = ena_i && (cnt_q == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clear_i || !ena_i)      cnt_q <= '0;
    else if (expire_o)               cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  // R9
  idle_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ena_i |-> (cnt_q == '0));
  // R5
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdk_status.sv
module wdk_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_det_i,
  input  logic       set_irq_i,
  input  logic       clr_wr_i,
  input  logic [1:0] clr_bits_i,
  output logic       det_o,
  output logic       irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      det_o <= set_det_i | (det_o & ~(clr_wr_i & clr_bits_i[0]));
      irq_o <= set_irq_i | (irq_o & ~(clr_wr_i & clr_bits_i[1]));
    end
  end

  // R7
  det_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_det_i |=> det_o);
  // R10
  det_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(det_o) |-> $past(clr_wr_i && clr_bits_i[0]));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdk_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1,
  parameter int MAX_SEL   = 30,
  parameter int SIM_SHIFT = 0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              echo_mode,
  output logic [15:0]       bus_rdata,
  output logic              sys_rst_req,
  output logic              wdog_irq
);
  localparam logic [SEL_W-1:0] SEL_TOP = SEL_W'(MAX_SEL);

  logic             ctl_wr, st_wr, commit, restart, expire;
  logic             ena_q, ren_q, det, irq, rst_req_q;
  logic [SEL_W-1:0] sel_q, sel_new;

  assign ctl_wr  = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR)) && !echo_mode;
  assign st_wr   = bus_wr && (bus_addr == ADDR_W'(STAT_ADDR));
  assign sel_new = (bus_wdata[SEL_W-1:0] > SEL_TOP) ? SEL_TOP : bus_wdata[SEL_W-1:0];

  wdk_keyseq u_keyseq (
    .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr), .data_i(bus_wdata),
    .commit_o(commit), .restart_o(restart)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= 1'b0;
      ren_q <= 1'b0;
      sel_q <= SEL_TOP;
    end else if (commit) begin
      ena_q <= bus_wdata[ENA_BIT];
      ren_q <= bus_wdata[REN_BIT];
      sel_q <= sel_new;
    end
  end

  wdk_timer #(.MAX_SEL(MAX_SEL), .SIM_SHIFT(SIM_SHIFT)) u_timer (
    .clk(clk), .rst_n(rst_n), .ena_i(ena_q), .sel_i(sel_q),
    .clear_i(commit | restart), .expire_o(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req_q <= 1'b0;
    else        rst_req_q <= expire && ren_q;
  end

  wdk_status u_status (
    .clk(clk), .rst_n(rst_n),
    .set_det_i(expire && ren_q), .set_irq_i(expire && !ren_q),
    .clr_wr_i(st_wr), .clr_bits_i(bus_wdata[1:0]),
    .det_o(det), .irq_o(irq)
  );

  assign sys_rst_req = rst_req_q;
  assign wdog_irq    = irq;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
      bus_rdata[ENA_BIT]     = ena_q;
      bus_rdata[REN_BIT]     = ren_q;
      bus_rdata[SEL_W-1:0]   = sel_q;
    end else if (bus_addr == ADDR_W'(STAT_ADDR)) begin
      bus_rdata[1:0] = {irq, det};
    end
  end

  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);
  // R7
  pulse_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> ($past(ena_q && ren_q) && det));
  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit) |-> ($stable(ena_q) && $stable(ren_q) && $stable(sel_q)));
  // R11
  echo_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (echo_mode && bus_wr) |=> ($stable(ena_q) && $stable(ren_q) && $stable(sel_q)));
  // R6
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q <= SEL_TOP);
endmodule

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
  localparam int SH = 22;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        echo_mode = 1'b0;
  logic [15:0] bus_rdata;
  logic        sys_rst_req, wdog_irq;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  keyed_watchdog #(.SIM_SHIFT(SH)) u_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .echo_mode(echo_mode), .bus_rdata(bus_rdata),
    .sys_rst_req(sys_rst_req), .wdog_irq(wdog_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  // Behavioural reference model
  int m_ena, m_ren, m_sel, m_cnt, m_st;
  bit m_det, m_irq, m_pulse;

  always @(posedge clk) begin
    int e, t, nxt;
    bit ev;
    if (!rst_n) begin
      m_ena = 0; m_ren = 0; m_sel = 30; m_cnt = 0; m_st = 0;
      m_det = 0; m_irq = 0; m_pulse = 0;
    end else begin
      e = m_sel - SH;
      if (e < 1) e = 1;
      t = 1 << e;
      ev = (m_ena != 0) && (m_cnt == t - 1);
      m_pulse = ev && (m_ren != 0);
      nxt = (m_ena == 0 || ev) ? 0 : m_cnt + 1;
      if (bus_wr && bus_addr == 2'd1) begin
        if (bus_wdata[0]) m_det = 0;
        if (bus_wdata[1]) m_irq = 0;
      end
      if (m_pulse) m_det = 1;
      if (ev && m_ren == 0) m_irq = 1;
      if (bus_wr && bus_addr == 2'd0 && !echo_mode) begin
        if (bus_wdata == 16'h3333) m_st = 1;
        else if (bus_wdata == 16'hCCCC) m_st = (m_st == 1) ? 2 : 0;
        else if (bus_wdata == 16'hAAAA) m_st = 3;
        else if (bus_wdata == 16'h5555) begin
          if (m_st == 3) nxt = 0;
          m_st = 0;
        end else begin
          if (m_st == 2) begin
            m_ena = bus_wdata[15];
            m_ren = bus_wdata[14];
            m_sel = (bus_wdata[4:0] > 5'd30) ? 30 : int'(bus_wdata[4:0]);
            nxt = 0;
          end
          m_st = 0;
        end
      end
      m_cnt = nxt;
    end
  end

  // Per-cycle comparison, away from both edges
  always @(posedge clk) begin
    int exp_rd;
    #2;
    if (rst_n) begin
      chk(sys_rst_req == m_pulse, "R7 pulse", sys_rst_req, m_pulse);
      chk(wdog_irq == m_irq, "R8 irq", wdog_irq, m_irq);
      exp_rd = 0;
      if (bus_addr == 2'd0) exp_rd = (m_ena << 15) | (m_ren << 14) | m_sel;
      else if (bus_addr == 2'd1) exp_rd = (int'(m_irq) << 1) | int'(m_det);
      chk(int'(bus_rdata) == exp_rd, "R4 read", bus_rdata, exp_rd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, input int expv, input string tag);
    bus_addr = a;
    #1;
    chk(int'(bus_rdata) == expv, tag, bus_rdata, expv);
    bus_addr = 2'd0;
  endtask

  task automatic wait_pulse(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!sys_rst_req && k < 2000);
  endtask

  task automatic count_pulses(input int n, output int p);
    p = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sys_rst_req) p++;
    end
  endtask

  task automatic unlock();
    wr(2'd0, 16'h3333);
    wr(2'd0, 16'hCCCC);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int k, p;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(2'd0, 16'h001E, "R1 ctrl");
    rd(2'd1, 0, "R1 status");
    chk(sys_rst_req == 1'b0 && wdog_irq == 1'b0, "R1 outputs", sys_rst_req, 0);
    // R2: plain write ignored
    wr(2'd0, 16'hC019);
    rd(2'd0, 16'h001E, "R2 locked");
    // R2 unlock and commit, exponent 25 -> 8 clocks
    unlock(); wr(2'd0, 16'hC019);
    rd(2'd0, 16'hC019, "R2 commit");
    wait_pulse(k); chk(k == 8, "R6 first expiry", k, 8);
    rd(2'd1, 1, "R7 status");
    @(negedge clk); chk(sys_rst_req == 1'b0, "R7 width", sys_rst_req, 0);
    // R5: restart pair and broken pair
    wait_pulse(k);
    wr(2'd0, 16'hAAAA); wr(2'd0, 16'h5555);
    wait_pulse(k); chk(k == 8, "R5 restart", k, 8);
    wr(2'd0, 16'hAAAA); wr(2'd0, 16'h1234); wr(2'd0, 16'h5555);
    wait_pulse(k); chk(k == 5, "R5 broken", k, 5);
    // R10
    wr(2'd1, 16'h0001); rd(2'd1, 0, "R10 clear det");
    // R3
    wr(2'd0, 16'h3333); wr(2'd0, 16'h0001); wr(2'd0, 16'hCCCC); wr(2'd0, 16'hC01A);
    rd(2'd0, 16'hC019, "R3 data between");
    wr(2'd0, 16'h3333); wr(2'd0, 16'hAAAA); wr(2'd0, 16'hCCCC); wr(2'd0, 16'hC01A);
    rd(2'd0, 16'hC019, "R3 key between");
    wr(2'd0, 16'hCCCC); wr(2'd0, 16'h3333); wr(2'd0, 16'hC01A);
    rd(2'd0, 16'hC019, "R3 order");
    // R4
    unlock(); wr(2'd0, 16'h5555);
    rd(2'd0, 16'hC019, "R4 key slot");
    wr(2'd0, 16'hC01A);
    rd(2'd0, 16'hC019, "R4 relock");
    // R6 clamp and extremes
    unlock(); wr(2'd0, 16'h401F);
    rd(2'd0, 16'h401E, "R6 clamp");
    unlock(); wr(2'd0, 16'hC000);
    wait_pulse(k); chk(k == 2, "R6 min exponent", k, 2);
    unlock(); wr(2'd0, 16'hC01A);
    wait_pulse(k); chk(k == 16, "R6 exponent 26", k, 16);
    // R8
    unlock(); wr(2'd0, 16'h8019);
    repeat (2) @(negedge clk);
    wr(2'd1, 16'h0003);
    count_pulses(40, p); chk(p == 0, "R8 no pulse", p, 0);
    chk(wdog_irq == 1'b1, "R8 irq", wdog_irq, 1);
    // R9 disarm
    unlock(); wr(2'd0, 16'h4019);
    @(negedge clk);
    wr(2'd1, 16'h0003);
    count_pulses(300, p); chk(p == 0 && wdog_irq == 1'b0, "R9 disarmed", p, 0);
    // R10 selective clear (status quiet while disarmed)
    unlock(); wr(2'd0, 16'h0019);
    unlock(); wr(2'd0, 16'h8019);
    repeat (9) @(negedge clk);
    unlock(); wr(2'd0, 16'h4019);
    wr(2'd1, 16'h0001); rd(2'd1, 2, "R10 keep irq");
    wr(2'd1, 16'h0002); rd(2'd1, 0, "R10 clear irq");
    // R9 rearm starts from zero; commit mid-count clears
    unlock(); wr(2'd0, 16'hC019);
    wait_pulse(k); chk(k == 8, "R9 rearm", k, 8);
    repeat (3) @(negedge clk);
    unlock(); wr(2'd0, 16'hC019);
    wait_pulse(k); chk(k == 8, "R9 commit clears", k, 8);
    // R11 echo blocking
    echo_mode = 1'b1;
    unlock(); wr(2'd0, 16'hC01A);
    rd(2'd0, 16'hC019, "R11 commit blocked");
    wait_pulse(k);
    wr(2'd0, 16'hAAAA); wr(2'd0, 16'h5555);
    wait_pulse(k); chk(k == 6, "R11 restart blocked", k, 6);
    wr(2'd0, 16'h3333);
    echo_mode = 1'b0;
    wr(2'd0, 16'hCCCC); wr(2'd0, 16'hC01A);
    rd(2'd0, 16'hC019, "R11 sequence blocked");
    repeat (4) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule